// File: doc/BRIEF.md
# Oscillator Trim Calibrator

This block searches for the 7-bit trim code that brings a tunable oscillator closest to a requested frequency. The caller gives a target in MHz and pulses a start input. The block turns the target into an expected meter count. It then measures with the trim code that is already applied. If that code already lands inside a ±4% window, the block finishes at once and keeps the code.

Otherwise the block bisects the full code range. For each probe it applies a trim code, waits a programmable number of settle cycles, starts an external frequency meter with a one-cycle pulse and waits for the meter's done strobe, which carries the count. Once the range has shrunk to two neighbouring codes, it measures both neighbours and keeps the one with the smaller error. It then measures once more at the chosen code and reports pass or fail against the window.

The trim output always holds the last code applied. A meter that never answers ends the run with a failure report.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, trim_o equals DEFAULT_CODE (64). done_o, pass_o, fail_o and meas_start_o are all 0.
- R2: The target count is target_mhz_i × 512 / 26, with the fraction dropped. It is captured when start_i is accepted in the idle state.
- R3: The first measurement of a run uses the trim code already applied. If that count is in the window (R6), the run ends after this single measurement with pass_o=1 and trim_o unchanged.
- R4: The bisection starts from low=0 and high=127. Each probe applies mid=(low+high)/2 and measures it. A count strictly above the target sets high to mid; any other count sets low to mid. The loop ends when the next mid equals low.
- R5: After the loop, the block measures at low and then at high. It applies whichever code has the smaller absolute error against the target. On equal errors it applies high.
- R6: The block measures once more at the applied code. The run passes when the count is strictly greater than target×960/1000 and strictly less than target×1040/1000, each product divided with the fraction dropped. Otherwise fail_o=1, and trim_o keeps the chosen code.
- R7: Every time trim_o changes, meas_start_o goes high exactly settle_cycles_i+1 cycles later. No measurement starts before the settle count has run out.
- R8: meas_start_o is a single-cycle pulse. The count is taken in the first cycle in which meas_done_i is high after that pulse, and trim_o stays stable while a measurement is in progress.
- R9: If meas_done_i stays low for TMO_CYCLES cycles after a start pulse, the run ends with fail_o=1 and trim_o unchanged.
- R10: Each run ends with a single-cycle done_o pulse. pass_o and fail_o are never high together, and they hold their value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration run (accepted only when idle) |
| target_mhz_i | input | MHZ_W | Target frequency in MHz |
| settle_cycles_i | input | SET_W | Settle wait after each trim change, in cycles |
| meas_start_o | output | 1 | One-cycle request to the frequency meter |
| meas_done_i | input | 1 | Meter result valid |
| meas_count_i | input | CNT_W | Meter count, valid with meas_done_i |
| trim_o | output | CODE_W | Trim code applied to the oscillator |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run ended inside the tolerance window |
| fail_o | output | 1 | Run ended outside the window or on timeout |

## Verification
The hardest case to reach is a tie between the two final endpoints. It needs a response in which the codes on either side of the target are exactly equally far from it, with the target itself derived from a MHz value. The bench meter models the oscillator as a signed linear curve. It picks slope 200 with an offset that places codes 49 and 50 exactly 100 counts either side of the 360 MHz target count. It picks the starting code so that the pre-check fails first. A too-steep curve gives the fail path, and a muted meter gives the timeout.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_REQ    = 2'd2,
    ST_WAIT   = 2'd3
  } cal_state_t;

  typedef enum logic [2:0] {
    PH_PRE    = 3'd0,
    PH_BISECT = 3'd1,
    PH_END_LO = 3'd2,
    PH_END_HI = 3'd3,
    PH_FINAL  = 3'd4
  } cal_phase_t;

  // meter count expected for a target in MHz (reference 26, 512 window)
  function automatic logic [31:0] mhz_to_count(input logic [31:0] mhz);
    return (mhz << 9) / 32'd26;
  endfunction

  function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // open window of +/-4 percent around the target
  function automatic logic in_band(input logic [31:0] cnt, input logic [31:0] tgt);
    logic [31:0] lo_lim;
    logic [31:0] hi_lim;
    lo_lim = (tgt * 32'd960) / 32'd1000;
    hi_lim = (tgt * 32'd1040) / 32'd1000;
    return (cnt > lo_lim) && (cnt < hi_lim);
  endfunction

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SET_W-1:0] value_i,
  output logic             zero_o
);
  logic [SET_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_i)      cnt_q <= value_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R7: the settle count falls by one each cycle it runs
  p_settle_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/trim_search_step.sv
module trim_search_step #(
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0] low_i,
  input  logic [CODE_W-1:0] high_i,
  input  logic [CODE_W-1:0] mid_i,
  input  logic              above_i,
  output logic [CODE_W-1:0] low_o,
  output logic [CODE_W-1:0] high_o,
  output logic [CODE_W-1:0] mid_o,
  output logic              last_o
);
  logic [CODE_W:0] sum;

  always_comb begin
    low_o  = above_i ? low_i : mid_i;
    high_o = above_i ? mid_i : high_i;
    sum    = {1'b0, low_o} + {1'b0, high_o};
    mid_o  = sum[CODE_W:1];
    last_o = (mid_o == low_o);
  end

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_trim_pkg::*;
#(
  parameter int CODE_W       = 7,
  parameter int CNT_W        = 16,
  parameter int MHZ_W        = 10,
  parameter int SET_W        = 16,
  parameter int TMO_CYCLES   = 256,
  parameter int DEFAULT_CODE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MHZ_W-1:0]  target_mhz_i,
  input  logic [SET_W-1:0]  settle_cycles_i,
  output logic              meas_start_o,
  input  logic              meas_done_i,
  input  logic [CNT_W-1:0]  meas_count_i,
  output logic [CODE_W-1:0] trim_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_FIRST = CODE_MAX >> 1;
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

  cal_state_t        state_q;
  cal_phase_t        phase_q;
  logic [CODE_W-1:0] trim_q, low_q, high_q;
  logic [CNT_W-1:0]  target_q, err_lo_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              done_q, pass_q, fail_q;

  // named internal events
  logic              settle_zero;
  logic              result_ev;
  logic              timeout_ev;
  logic              band_ok;
  logic              above;
  logic [CNT_W-1:0]  err_now;
  logic [CODE_W-1:0] nx_low, nx_high, nx_mid;
  logic              nx_last;

  assign result_ev  = (state_q == ST_WAIT) && meas_done_i;
  assign timeout_ev = (state_q == ST_WAIT) && !meas_done_i && (tmo_q == TMO_LAST);
  assign above      = (meas_count_i > target_q);
  assign band_ok    = in_band(32'(meas_count_i), 32'(target_q));
  assign err_now    = CNT_W'(abs_diff(32'(meas_count_i), 32'(target_q)));

  trim_settle_timer #(.SET_W(SET_W)) i_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (state_q != ST_SETTLE),
    .value_i (settle_cycles_i),
    .zero_o  (settle_zero)
  );

  trim_search_step #(.CODE_W(CODE_W)) i_step (
    .low_i   (low_q),
    .high_i  (high_q),
    .mid_i   (trim_q),
    .above_i (above),
    .low_o   (nx_low),
    .high_o  (nx_high),
    .mid_o   (nx_mid),
    .last_o  (nx_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_PRE;
      trim_q   <= CODE_W'(DEFAULT_CODE);
      low_q    <= '0;
      high_q   <= CODE_MAX;
      target_q <= '0;
      err_lo_q <= '0;
      tmo_q    <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          target_q <= CNT_W'(mhz_to_count(32'(target_mhz_i)));
          phase_q  <= PH_PRE;
          pass_q   <= 1'b0;
          fail_q   <= 1'b0;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_zero) state_q <= ST_REQ;
        ST_REQ: begin
          tmo_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (result_ev) begin
            state_q <= ST_SETTLE;
            unique case (phase_q)
              PH_PRE: begin
                if (band_ok) begin
                  done_q  <= 1'b1;
                  pass_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  low_q   <= '0;
                  high_q  <= CODE_MAX;
                  trim_q  <= CODE_FIRST;
                  phase_q <= PH_BISECT;
                end
              end
              PH_BISECT: begin
                low_q  <= nx_low;
                high_q <= nx_high;
                if (nx_last) begin
                  trim_q  <= nx_low;
                  phase_q <= PH_END_LO;
                end else begin
                  trim_q <= nx_mid;
                end
              end
              PH_END_LO: begin
                err_lo_q <= err_now;
                trim_q   <= high_q;
                phase_q  <= PH_END_HI;
              end
              PH_END_HI: begin
                trim_q  <= (err_lo_q < err_now) ? low_q : high_q;
                phase_q <= PH_FINAL;
              end
              default: begin
                done_q  <= 1'b1;
                pass_q  <= band_ok;
                fail_q  <= !band_ok;
                state_q <= ST_IDLE;
              end
            endcase
          end else if (timeout_ev) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign meas_start_o = (state_q == ST_REQ);
  assign trim_o       = trim_q;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign fail_o       = fail_q;

  // R8: the meter request lasts one cycle
  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start_o |=> !meas_start_o);
  // R8: trim does not move while the meter is counting
  p_trim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> $stable(trim_q));
  // R7: a request only follows an expired settle count
  p_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start_o |-> $past(settle_zero));
  // R10: end-of-run strobe is a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: verdict flags are exclusive
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));
  // R4: the search interval stays ordered while bisecting
  p_range_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BISECT && state_q != ST_IDLE) |-> (low_q < high_q));
  // R9: a timeout always ends the run as a failure
  p_timeout_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (done_o && fail_o));

endmodule

// File: tb/test_osc_trim_cal.sv
module test_osc_trim_cal;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [9:0]  target_mhz_i = '0;
  logic [15:0] settle_cycles_i = '0;
  logic        meas_start_o;
  logic        meas_done_i = 1'b0;
  logic [15:0] meas_count_i = '0;
  logic [6:0]  trim_o;
  logic        done_o, pass_o, fail_o;

  always #4 clk = ~clk;

  osc_trim_cal i_osc_trim_cal (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_mhz_i(target_mhz_i),
    .settle_cycles_i(settle_cycles_i), .meas_start_o(meas_start_o),
    .meas_done_i(meas_done_i), .meas_count_i(meas_count_i), .trim_o(trim_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o));

  int checks = 0;
  int errors = 0;
  int slope = 40;
  int offs = 5000;
  bit mute = 1'b0;
  int nmeas = 0;
  int cyc = 0;
  int chg_cyc = 0;
  bit chg_pend = 1'b0;
  logic [6:0] last_trim = 7'd64;
  int cur_code = 64;
  bit finished = 1'b0;

  typedef struct {int code; bit pass; bit fail; int n; string tag;} exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model(input int code);
    int v;
    v = slope * code + offs;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return v;
  endfunction

  function automatic bit window_ok(input int m, input int t);
    return (m > (t * 960) / 1000) && (m < (t * 1040) / 1000);
  endfunction

  // spec model of a run, written from the requirements
  function automatic exp_t predict(input int mhz, input int cur, input string tag);
    exp_t e;
    int t, lo, hi, mid, elo, ehi;
    t = (mhz * 512) / 26;
    e.tag = tag; e.n = 1; e.fail = 1'b0;
    if (window_ok(model(cur), t)) begin
      e.code = cur; e.pass = 1'b1;
      return e;
    end
    lo = 0; hi = 127;
    forever begin
      mid = (lo + hi) / 2;
      if (mid == lo) break;
      e.n++;
      if (model(mid) > t) hi = mid; else lo = mid;
    end
    elo = model(lo) - t; if (elo < 0) elo = -elo;
    ehi = model(hi) - t; if (ehi < 0) ehi = -ehi;
    e.code = (elo < ehi) ? lo : hi;
    e.n += 3;
    e.pass = window_ok(model(e.code), t);
    e.fail = !e.pass;
    return e;
  endfunction

  // meter model
  initial begin
    forever begin
      @(negedge clk);
      meas_done_i = 1'b0;
      if (meas_start_o && !mute) begin
        repeat (LAT) @(negedge clk);
        meas_count_i = 16'(model(int'(trim_o)));
        meas_done_i = 1'b1;
      end
    end
  end

  // monitor: settle spacing and scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n && trim_o !== last_trim) begin
      chg_cyc = cyc; chg_pend = 1'b1; last_trim = trim_o;
    end
    if (meas_start_o) begin
      nmeas++;
      if (chg_pend) begin
        check(cyc - chg_cyc == int'(settle_cycles_i) + 1, "R7 settle spacing",
              cyc - chg_cyc, int'(settle_cycles_i) + 1);
        chg_pend = 1'b0;
      end
    end
    if (done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(trim_o) == e.code, {e.tag, " code"}, int'(trim_o), e.code);
        check(pass_o == e.pass, {e.tag, " pass"}, pass_o, e.pass);
        check(fail_o == e.fail, {e.tag, " fail"}, fail_o, e.fail);
        check(nmeas == e.n, {e.tag, " measurements"}, nmeas, e.n);
      end
      nmeas = 0;
    end
  end

  task automatic run_case(input int mhz, input int settle, input string tag, input bit tmo);
    exp_t e;
    if (tmo) begin
      e.code = cur_code; e.pass = 1'b0; e.fail = 1'b1; e.n = 1; e.tag = tag;
    end else begin
      e = predict(mhz, cur_code, tag);
    end
    exp_q.push_back(e);
    @(negedge clk);
    target_mhz_i = 10'(mhz);
    settle_cycles_i = 16'(settle);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    // R10: verdict holds after the done pulse
    repeat (2) @(negedge clk);
    check(pass_o == e.pass && fail_o == e.fail, {"R10 hold ", tag}, pass_o, e.pass);
    cur_code = e.code;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(trim_o == 7'd64, "R1 reset trim", trim_o, 64);
    check(!done_o && !pass_o && !fail_o, "R1 reset flags", {done_o, pass_o, fail_o}, 0);
    check(!meas_start_o, "R1 reset start", meas_start_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    slope = 40; offs = 5000;
    run_case(360, 5, "R2/R4/R5/R6 360MHz", 1'b0);
    run_case(326, 2, "R2/R4/R6 326MHz", 1'b0);
    run_case(326, 4, "R3 skip", 1'b0);
    slope = 200; offs = -2811;
    run_case(360, 0, "R5 tie", 1'b0);
    check(cur_code == 50, "R5 tie keeps high", cur_code, 50);
    slope = 2000; offs = 0;
    run_case(360, 1, "R6 out of band", 1'b0);
    mute = 1'b1;
    run_case(360, 3, "R9 timeout", 1'b1);
    mute = 1'b0;
    slope = 40; offs = 5000;
    run_case(360, 7, "R8 recovery", 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule